// File: doc/BRIEF.md
# Double-Data-Rate Output Serializer

The serializer takes a parallel word from the core clock domain and sends it out on a single pin at two bits per clock cycle. Each cycle's bit pair sits in two one-bit output registers, one holding the leading bit and one holding the trailing bit. A 2:1 multiplexer selected by the clock level itself passes one register during the high phase and the other during the low phase. The pin therefore carries a new bit in each half period.

Three elaboration-time switches set the output stage. The first two pick the clock edge that loads each output register. The third picks which clock level passes the leading bit. Only the four settings that keep every leading bit ahead of its trailing partner on the pin are accepted; any other setting halts elaboration. The default loads the leading register on the falling edge and the trailing register on the rising edge, and shows the leading bit while the clock is high. In this setting both registers are shown in the later half of their hold time, so a register whose data arrives late keeps half a cycle of slack before the bit order breaks.

Words enter through a valid/ready handshake and leave most significant bit first. When no word is pending, the pin carries a steady one-zero idle pattern.

Top module: `ddr_serializer`

## Requirements
- R1: In the default setting (leading register on the falling edge, trailing register on the rising edge, leading bit shown while the clock is high), the pin changes at most at each clock edge, holds each bit for one full clock phase, and shows the leading bit of a pair immediately before its trailing bit.
- R2: Three more settings give the same pin stream as the default: both registers on the rising edge with the leading bit shown while the clock is high; leading on falling, trailing on rising, with the leading bit shown while the clock is low; and both registers on the falling edge with the leading bit shown while the clock is low. Any other setting, or an odd word width, stops elaboration with an error.
- R3: A word of DATA_W bits goes out as DATA_W/2 pairs, most significant bit first. Bit DATA_W-1 is the leading bit of the first pair and bit DATA_W-2 is its trailing bit.
- R4: With no word in progress, including right after reset, every pair sent is (leading 1, trailing 0), so the pin alternates 1,0,1,0.
- R5: inReady is high when no pair is left to send or only the last pair of the current word remains. A word is taken on a rising edge with inValid and inReady both high, and inReady then stays low for exactly DATA_W/2-1 cycles.
- R6: A word accepted while the previous word's last pair is being sent follows that pair on the pin with no idle pair in between.
- R7: A synchronous active-high reset drops any word in progress. It loads both output registers and the pair register with the idle pair and leaves inReady high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the select of the output multiplexer |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A word is offered on inData |
| inReady | output | 1 | The serializer can take a word this cycle |
| inData | input | DATA_W | Parallel word to send, MSB first |
| serOut | output | 1 | Serial pin, two bits per clock cycle |

## Verification
The bench drives one copy of the block for each of the four legal settings with the same traffic. It samples each pin in the middle of every clock phase and looks for the expected bit string, framed by idle pairs, in each recorded stream. A wrong select polarity or a register on the wrong edge swaps or misaligns bits within a pair, so the string is not found. Back-to-back words with all-zero and all-one patterns expose a dropped or duplicated pair at a word boundary, which would show up as an idle gap or a repeated pair. A reset in the middle of an all-ones word catches leftover shift state, which would break the alternating idle pattern. Each accept checks the number of cycles inReady stays low, which catches an off-by-one in the pair count.

// File: rtl/ddrser_pkg.sv
package ddrser_pkg;

  // Strobes from control to the shifter.
  typedef struct packed {
    logic loadWord;   // capture inData into the shift register
    logic takePair;   // move the top pair into the pair register
  } ser_ctrl_t;

  localparam logic IDLE_LEAD  = 1'b1;
  localparam logic IDLE_TRAIL = 1'b0;

endpackage

// File: rtl/ddrser_ctrl.sv
module ddrser_ctrl
  import ddrser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output logic      inReady,
  output ser_ctrl_t ctrlStrobe
);

  localparam int PAIRS = DATA_W / 2;
  localparam int CNT_W = $clog2(PAIRS + 1);

  logic [CNT_W-1:0] pairsLeft;

  // Ready while empty or while the last pair is leaving.
  assign inReady              = (pairsLeft <= CNT_W'(1));
  assign ctrlStrobe.loadWord  = inValid && inReady;
  assign ctrlStrobe.takePair  = (pairsLeft != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pairsLeft <= '0;
    end else if (ctrlStrobe.loadWord) begin
      pairsLeft <= CNT_W'(PAIRS);
    end else if (ctrlStrobe.takePair) begin
      pairsLeft <= pairsLeft - CNT_W'(1);
    end
  end

endmodule

// File: rtl/ddrser_shifter.sv
module ddrser_shifter
  import ddrser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  ser_ctrl_t         ctrlStrobe,
  output logic              pairFirst,
  output logic              pairSecond
);

  if ((DATA_W < 2) || (DATA_W % 2 != 0)) begin : g_bad_width
    $error("ddrser_shifter: DATA_W must be even and at least 2");
  end

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg   <= '0;
      pairFirst  <= IDLE_LEAD;
      pairSecond <= IDLE_TRAIL;
    end else begin
      if (ctrlStrobe.loadWord) begin
        shiftReg <= inData;
      end else if (ctrlStrobe.takePair) begin
        shiftReg <= shiftReg << 2;
      end
      if (ctrlStrobe.takePair) begin
        pairFirst  <= shiftReg[DATA_W-1];
        pairSecond <= shiftReg[DATA_W-2];
      end else begin
        pairFirst  <= IDLE_LEAD;
        pairSecond <= IDLE_TRAIL;
      end
    end
  end

endmodule

// File: rtl/ddrser_edge_stage.sv
module ddrser_edge_stage
  import ddrser_pkg::*;
#(
  parameter bit FIRST_ON_RISE  = 1'b0,
  parameter bit SECOND_ON_RISE = 1'b1,
  parameter bit FIRST_WHEN_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pairFirst,
  input  logic pairSecond,
  output logic serOut
);

  localparam bit LEGAL =
      ( FIRST_ON_RISE &&  SECOND_ON_RISE && !FIRST_WHEN_LOW) ||
      (!FIRST_ON_RISE &&  SECOND_ON_RISE                   ) ||
      (!FIRST_ON_RISE && !SECOND_ON_RISE &&  FIRST_WHEN_LOW);

  if (!LEGAL) begin : g_bad_cfg
    $error("ddrser_edge_stage: edge/select setting reorders bits");
  end

  logic firstQ;
  logic secondQ;

  if (FIRST_ON_RISE) begin : g_first_rise
    always_ff @(posedge clk) begin
      if (rst) firstQ <= IDLE_LEAD;
      else     firstQ <= pairFirst;
    end
  end else begin : g_first_fall
    always_ff @(negedge clk) begin
      if (rst) firstQ <= IDLE_LEAD;
      else     firstQ <= pairFirst;
    end
  end

  if (SECOND_ON_RISE) begin : g_second_rise
    always_ff @(posedge clk) begin
      if (rst) secondQ <= IDLE_TRAIL;
      else     secondQ <= pairSecond;
    end
  end else begin : g_second_fall
    always_ff @(negedge clk) begin
      if (rst) secondQ <= IDLE_TRAIL;
      else     secondQ <= pairSecond;
    end
  end

  // Clock-level multiplexer: leading register passes on the chosen level.
  always_comb begin
    if (clk ^ FIRST_WHEN_LOW) serOut = firstQ;
    else                      serOut = secondQ;
  end

endmodule

// File: rtl/ddr_serializer.sv
module ddr_serializer
  import ddrser_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter bit FIRST_ON_RISE  = 1'b0,
  parameter bit SECOND_ON_RISE = 1'b1,
  parameter bit FIRST_WHEN_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              serOut
);

  ser_ctrl_t ctrlStrobe;
  logic      pairFirst;
  logic      pairSecond;

  ddrser_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inReady    (inReady),
    .ctrlStrobe (ctrlStrobe)
  );

  ddrser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .inData     (inData),
    .ctrlStrobe (ctrlStrobe),
    .pairFirst  (pairFirst),
    .pairSecond (pairSecond)
  );

  ddrser_edge_stage #(
    .FIRST_ON_RISE  (FIRST_ON_RISE),
    .SECOND_ON_RISE (SECOND_ON_RISE),
    .FIRST_WHEN_LOW (FIRST_WHEN_LOW)
  ) u_edge (
    .clk        (clk),
    .rst        (rst),
    .pairFirst  (pairFirst),
    .pairSecond (pairSecond),
    .serOut     (serOut)
  );

endmodule

// File: rtl/ddrser_chk.sv
module ddrser_chk
  import ddrser_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter bit FIRST_ON_RISE  = 1'b0,
  parameter bit SECOND_ON_RISE = 1'b1,
  parameter bit FIRST_WHEN_LOW = 1'b0
) (
  input logic      clk,
  input logic      rst,
  input logic      inValid,
  input logic      inReady,
  input ser_ctrl_t ctrlStrobe,
  input logic      pairFirst,
  input logic      pairSecond,
  input logic      serOut
);

  localparam int PAIRS    = DATA_W / 2;
  localparam bit LOW_RISE = FIRST_WHEN_LOW ? FIRST_ON_RISE : SECOND_ON_RISE;

  logic lowSrc;
  logic highSrc;
  assign lowSrc  = FIRST_WHEN_LOW ? pairFirst  : pairSecond;
  assign highSrc = FIRST_WHEN_LOW ? pairSecond : pairFirst;

  // Pin value late in the low phase, seen at the rising edge.
  if (LOW_RISE) begin : g_low_rise
    AST_LOW_PHASE_BIT: assert property (@(posedge clk) disable iff (rst)
      serOut == $past(lowSrc)); // R1
  end else begin : g_low_fall
    AST_LOW_PHASE_BIT: assert property (@(posedge clk) disable iff (rst)
      serOut == lowSrc); // R1
  end

  // Pin value late in the high phase, seen at the falling edge.
  AST_HIGH_PHASE_BIT: assert property (@(negedge clk) disable iff (rst)
    serOut == $past(highSrc)); // R1

  AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (rst)
    !ctrlStrobe.takePair |=> (pairFirst && !pairSecond)); // R4

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !ctrlStrobe.takePair |-> inReady); // R5

  if (PAIRS > 1) begin : g_busy
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (inValid && inReady) |=> !inReady); // R5
  end

endmodule

bind ddr_serializer ddrser_chk #(
  .DATA_W         (DATA_W),
  .FIRST_ON_RISE  (FIRST_ON_RISE),
  .SECOND_ON_RISE (SECOND_ON_RISE),
  .FIRST_WHEN_LOW (FIRST_WHEN_LOW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inReady    (inReady),
  .ctrlStrobe (ctrlStrobe),
  .pairFirst  (pairFirst),
  .pairSecond (pairSecond),
  .serOut     (serOut)
);

// File: tb/tb_ddr_serializer.sv
module tb_ddr_serializer;

  localparam int W     = 8;
  localparam int PAIRS = W / 2;
  localparam int NCFG  = 4;
  localparam int RECN  = 1024;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic         inReady;
  logic [1:0]   readyOther;
  logic         readyNN;
  logic [NCFG-1:0] pin;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // cfg 0: falling/rising, lead shown high (default)
  ddr_serializer #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inData(inData), .serOut(pin[0]));
  // cfg 1: rising/rising, lead shown high
  ddr_serializer #(.DATA_W(W), .FIRST_ON_RISE(1'b1), .SECOND_ON_RISE(1'b1),
    .FIRST_WHEN_LOW(1'b0)) dutRiseRise (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(readyOther[0]),
    .inData(inData), .serOut(pin[1]));
  // cfg 2: falling/rising, lead shown low
  ddr_serializer #(.DATA_W(W), .FIRST_ON_RISE(1'b0), .SECOND_ON_RISE(1'b1),
    .FIRST_WHEN_LOW(1'b1)) dutFallRiseLow (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(readyOther[1]),
    .inData(inData), .serOut(pin[2]));
  // cfg 3: falling/falling, lead shown low
  ddr_serializer #(.DATA_W(W), .FIRST_ON_RISE(1'b0), .SECOND_ON_RISE(1'b0),
    .FIRST_WHEN_LOW(1'b1)) dutFallFall (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(readyNN),
    .inData(inData), .serOut(pin[3]));

  // Stream recorder: one sample in the middle of each clock phase.
  bit rec [0:NCFG-1][0:RECN-1];
  int recLen = 0;
  bit recording = 0;

  always begin
    @(posedge clk);
    #5;
    if (recording && recLen < RECN) begin
      for (int c = 0; c < NCFG; c++) rec[c][recLen] = pin[c];
      recLen++;
    end
    @(negedge clk);
    #5;
    if (recording && recLen < RECN) begin
      for (int c = 0; c < NCFG; c++) rec[c][recLen] = pin[c];
      recLen++;
    end
  end

  bit expSeq [0:255];
  int expLen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic expClear();
    expLen = 0;
  endtask

  task automatic expIdle();
    expSeq[expLen] = 1'b1;
    expSeq[expLen+1] = 1'b0;
    expLen += 2;
  endtask

  task automatic expWord(input logic [W-1:0] w);
    for (int b = W - 1; b >= 0; b--) begin
      expSeq[expLen] = w[b];
      expLen++;
    end
  endtask

  function automatic int findSeq(input int c);
    for (int s = 0; s + expLen <= recLen; s++) begin
      bit ok = 1;
      for (int k = 0; k < expLen; k++) begin
        if (rec[c][s+k] != expSeq[k]) ok = 0;
      end
      if (ok) return s;
    end
    return -1;
  endfunction

  task automatic checkStream(input string defReq, input string altReq);
    for (int c = 0; c < NCFG; c++) begin
      int pos = findSeq(c);
      chk(pos >= 0, (c == 0) ? defReq : altReq, pos, 0);
    end
  endtask

  task automatic checkAlternating(input string req);
    for (int c = 0; c < NCFG; c++) begin
      int bad = 0;
      for (int i = 0; i + 1 < recLen; i++) begin
        if (rec[c][i] == rec[c][i+1]) bad++;
      end
      chk(bad == 0 && recLen > 8, req, bad, 0);
    end
  endtask

  task automatic startRec();
    recLen = 0;
    recording = 1;
  endtask

  task automatic stopRec();
    recording = 0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  // Offer one word, then count the cycles inReady stays low (R5).
  task automatic sendWord(input logic [W-1:0] w);
    int lowCnt = 0;
    while (!inReady) cycles(1);
    inValid = 1'b1;
    inData  = w;
    cycles(1);
    inValid = 1'b0;
    while (!inReady) begin
      lowCnt++;
      cycles(1);
    end
    chk(lowCnt == PAIRS - 1, "R5 busy window", lowCnt, PAIRS - 1);
  endtask

  task automatic testReset();
    chk(inReady == 1'b1, "R5 ready after reset", int'(inReady), 1);
    startRec();
    cycles(12);
    stopRec();
    checkAlternating("R4 idle after reset");
  endtask

  task automatic testSingleWord(input logic [W-1:0] w);
    startRec();
    cycles(3);
    sendWord(w);
    cycles(6);
    stopRec();
    expClear();
    expIdle();
    expWord(w);
    expIdle();
    checkStream("R1 R3 single word", "R2 R3 single word");
  endtask

  task automatic testBackToBack();
    logic [W-1:0] words [0:4];
    words[0] = 8'h3A; words[1] = 8'h00; words[2] = 8'hFF;
    words[3] = 8'h96; words[4] = 8'hF0;
    startRec();
    cycles(3);
    for (int i = 0; i < 5; i++) sendWord(words[i]);
    cycles(6);
    stopRec();
    expClear();
    expIdle();
    for (int i = 0; i < 5; i++) expWord(words[i]);
    expIdle();
    checkStream("R6 back-to-back", "R2 R6 back-to-back");
  endtask

  task automatic testResetMidWord();
    while (!inReady) cycles(1);
    inValid = 1'b1;
    inData  = 8'hFF;
    cycles(1);
    inValid = 1'b0;
    cycles(1);
    rst = 1'b1;
    cycles(3);
    rst = 1'b0;
    chk(inReady == 1'b1, "R7 ready after reset", int'(inReady), 1);
    startRec();
    cycles(12);
    stopRec();
    checkAlternating("R7 word dropped");
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    cycles(4);
    rst = 1'b0;
    cycles(2);
    testReset();
    testSingleWord(8'hC5);
    testSingleWord(8'h81);
    testBackToBack();
    testResetMidWord();
    testSingleWord(8'h6B);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule